// File: doc/BRIEF.md
# Locking Multi-Policy Stream Arbiter

This block shares one write port into a buffer memory among four byte-stream sources. Each source raises a request, drives an 8-bit data byte every cycle it is active, and marks the final byte of its stream. The arbiter picks one winner while it is idle and locks onto it. It then forwards the winner's bytes, a valid flag, an end-of-stream flag and the winner's index until that stream ends. After the end it spends one idle cycle and then arbitrates again.

A two-bit policy input chooses how the winner is picked, and it is read only at the moment of arbitration. The fixed policy always prefers the lowest index. The rotating policy moves its top-priority slot one place forward after each stream it served, independent of who won. The round-robin policy hands the top slot to the source just after the most recent winner. Each of the last two policies keeps its own pointer, and only streams granted under that policy move it.

The block is a two-state machine. IDLE moves to LOCKED (transition *grant*) when at least one request is present. LOCKED moves back to IDLE (transition *release*) on the cycle the locked source shows its last byte. Otherwise each state holds (transitions *wait* and *stream*).

Top module: `stream_lock_arb`

## Requirements
- R1: While locked, `gnt_o` is one-hot on the locked source, `gnt_idx_o` is its index, and `out_data_o` equals that source's byte in the same cycle (source k's byte is `data_i[8k+7:8k]`).
- R2: With `mode_sel` = 0 (or the reserved code 3), an arbitration grants the lowest-numbered requesting source.
- R3: Once granted, the lock does not change until the locked source asserts request and last together. Requests from any other source, including higher-priority ones, have no effect on `gnt_o` during that time.
- R4: With `mode_sel` = 1, the grant goes to the first requester found when scanning upward circularly from a rotating pointer. The pointer advances by one, modulo 4, after each stream that was granted under this policy completes.
- R5: With `mode_sel` = 2, the grant goes to the first requester scanning upward circularly from a round-robin pointer. After a stream granted under this policy completes, the pointer becomes the winner's index plus one, modulo 4.
- R6: At most one bit of `gnt_o` is ever set.
- R7: An arbitration in an idle cycle with requests present shows its grant after the next rising edge. If the last byte is seen in cycle t, `gnt_o` is zero in cycle t+1, and the next grant appears no earlier than cycle t+2.
- R8: With no grant, `out_valid_o` and `out_last_o` are low. If no request is present in an idle cycle, no grant follows.
- R9: `mode_sel` is sampled only at arbitration. Changing it during a locked stream alters neither the current grant nor the pointer update that stream makes.
- R10: Synchronous active-low reset clears the grant and sets both rotating pointers to source 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Policy: 0 fixed, 1 rotating, 2 round robin, 3 as fixed |
| req_i | input | 4 | Per-source request / byte valid |
| last_i | input | 4 | Per-source final-byte marker |
| data_i | input | 32 | Packed source bytes, source k at bits 8k+7:8k |
| gnt_o | output | 4 | One-hot grant |
| gnt_idx_o | output | 2 | Index of the granted source |
| out_valid_o | output | 1 | Forwarded byte is valid |
| out_data_o | output | 8 | Forwarded byte |
| out_last_o | output | 1 | Forwarded byte is the last of its stream |

## Verification
A grant decided in an idle cycle becomes visible one edge later. The data, valid and last outputs are combinational from the locked index, so they are due in the same cycle as the input byte. The bench drives inputs on falling edges. It checks the grant one falling edge after the request is set, and it checks the data outputs a short delay after driving each byte, inside that cycle. After each final byte it checks, on the following falling edge, that the block is idle, which covers the one-cycle gap required by R7. The bench keeps its own model of both pointers and advances them only after each stream completes.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        POL_FIXED  = 2'd0,
        POL_ROTATE = 2'd1,
        POL_RR     = 2'd2,
        POL_RSVD   = 2'd3
    } arb_pol_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_LOCKED = 1'b1
    } arb_state_e;
endpackage

// File: rtl/rot_pick.sv
module rot_pick #(
    parameter int NUM_REQ = 4,
    localparam int IDX_W  = $clog2(NUM_REQ)
) (
    input  logic [NUM_REQ-1:0] req,
    input  logic [IDX_W-1:0]   base,
    output logic               found,
    output logic [IDX_W-1:0]   win
);
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int k = 0; k < NUM_REQ; k++) begin
            logic [IDX_W-1:0] cand;
            cand = base + IDX_W'(k);
            if (!found && req[cand]) begin
                found = 1'b1;
                win   = cand;
            end
        end
    end
endmodule

// File: rtl/ptr_ctrl.sv
module ptr_ctrl #(
    parameter int NUM_REQ = 4,
    localparam int IDX_W  = $clog2(NUM_REQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_rot,
    input  logic             step_rr,
    input  logic [IDX_W-1:0] last_win,
    output logic [IDX_W-1:0] rot_ptr,
    output logic [IDX_W-1:0] rr_ptr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rot_ptr <= '0;
            rr_ptr  <= '0;
        end else begin
            if (step_rot) rot_ptr <= rot_ptr + IDX_W'(1);
            if (step_rr)  rr_ptr  <= last_win + IDX_W'(1);
        end
    end
endmodule

// File: rtl/byte_sel.sv
module byte_sel #(
    parameter int NUM_REQ = 4,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = $clog2(NUM_REQ)
) (
    input  logic [NUM_REQ*DATA_W-1:0] din,
    input  logic [IDX_W-1:0]          sel,
    output logic [DATA_W-1:0]         dout
);
    logic [DATA_W-1:0] lane [NUM_REQ];

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_lane
        assign lane[g] = din[g*DATA_W +: DATA_W];
    end

    assign dout = lane[sel];
endmodule

// File: rtl/stream_lock_arb.sv
module stream_lock_arb
    import arb_pkg::*;
#(
    parameter int NUM_REQ = 4,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = $clog2(NUM_REQ)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                mode_sel,
    input  logic [NUM_REQ-1:0]        req_i,
    input  logic [NUM_REQ-1:0]        last_i,
    input  logic [NUM_REQ*DATA_W-1:0] data_i,
    output logic [NUM_REQ-1:0]        gnt_o,
    output logic [IDX_W-1:0]          gnt_idx_o,
    output logic                      out_valid_o,
    output logic [DATA_W-1:0]         out_data_o,
    output logic                      out_last_o
);
    arb_state_e       state_q, state_d;
    arb_pol_e         pol_now, lk_pol_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] rot_ptr, rr_ptr, scan_base, pick_idx;
    logic             pick_found, locked, stream_end;

    assign pol_now = arb_pol_e'(mode_sel);

    always_comb begin
        unique case (pol_now)
            POL_ROTATE: scan_base = rot_ptr;
            POL_RR:     scan_base = rr_ptr;
            default:    scan_base = '0;
        endcase
    end

    rot_pick #(.NUM_REQ(NUM_REQ)) pick_i (
        .req   (req_i),
        .base  (scan_base),
        .found (pick_found),
        .win   (pick_idx)
    );

    assign locked     = (state_q == ST_LOCKED);
    assign stream_end = locked && req_i[idx_q] && last_i[idx_q];

    // next-state logic: wait / grant / stream / release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (pick_found) state_d = ST_LOCKED;
            ST_LOCKED: if (stream_end) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            lk_pol_q <= POL_FIXED;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && pick_found) begin
                idx_q    <= pick_idx;
                lk_pol_q <= pol_now;
            end
        end
    end

    ptr_ctrl #(.NUM_REQ(NUM_REQ)) ptr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_rot (stream_end && lk_pol_q == POL_ROTATE),
        .step_rr  (stream_end && lk_pol_q == POL_RR),
        .last_win (idx_q),
        .rot_ptr  (rot_ptr),
        .rr_ptr   (rr_ptr)
    );

    byte_sel #(.NUM_REQ(NUM_REQ), .DATA_W(DATA_W)) mux_i (
        .din  (data_i),
        .sel  (idx_q),
        .dout (out_data_o)
    );

    always_comb begin
        gnt_o       = '0;
        out_valid_o = 1'b0;
        out_last_o  = 1'b0;
        gnt_idx_o   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                gnt_o = '0;
            end
            ST_LOCKED: begin
                gnt_o[idx_q] = 1'b1;
                out_valid_o  = req_i[idx_q];
                out_last_o   = stream_end;
            end
        endcase
    end
endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
    parameter int NUM_REQ = 4,
    localparam int IDX_W  = $clog2(NUM_REQ)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         mode_sel,
    input logic [NUM_REQ-1:0] req_i,
    input logic [NUM_REQ-1:0] gnt_o,
    input logic [IDX_W-1:0]   gnt_idx_o,
    input logic               out_valid_o,
    input logic               out_last_o
);
    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o)); // R6

    AST_IDX_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0) |-> gnt_o[gnt_idx_o]); // R1

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0 && !out_last_o) |=> $stable(gnt_o)); // R3

    AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        out_last_o |=> (gnt_o == '0)); // R7

    AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o == '0 && req_i != '0 && (mode_sel == 2'd0 || mode_sel == 2'd3))
        |=> (gnt_o == ($past(req_i) & (~$past(req_i) + NUM_REQ'(1))))); // R2

    AST_NO_REQ_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o == '0 && req_i == '0) |=> (gnt_o == '0)); // R8

    AST_VALID_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o || out_last_o) |-> (gnt_o != '0)); // R8
endmodule

bind stream_lock_arb arb_chk #(.NUM_REQ(NUM_REQ)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sel    (mode_sel),
    .req_i       (req_i),
    .gnt_o       (gnt_o),
    .gnt_idx_o   (gnt_idx_o),
    .out_valid_o (out_valid_o),
    .out_last_o  (out_last_o)
);

// File: tb/stream_lock_arb_tb_top.sv
module stream_lock_arb_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'd0;
    logic [3:0]  req_i = '0;
    logic [3:0]  last_i = '0;
    logic [31:0] data_i = '0;
    logic [3:0]  gnt_o;
    logic [1:0]  gnt_idx_o;
    logic        out_valid_o;
    logic [7:0]  out_data_o;
    logic        out_last_o;

    int n_chk = 0;
    int n_bad = 0;
    int rot_m = 0;
    int rr_m  = 0;

    stream_lock_arb dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .req_i(req_i),
        .last_i(last_i), .data_i(data_i), .gnt_o(gnt_o), .gnt_idx_o(gnt_idx_o),
        .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_last_o(out_last_o)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pattern(input int ch, input int b);
        return 8'((ch * 16 + b) ^ 8'h5A);
    endfunction

    task automatic put_bytes(input int b);
        for (int ch = 0; ch < 4; ch++) data_i[ch*8 +: 8] = pattern(ch, b);
    endtask

    function automatic int model_pick(input logic [3:0] mask, input int base);
        for (int k = 0; k < 4; k++) begin
            if (mask[(base + k) % 4]) return (base + k) % 4;
        end
        return 0;
    endfunction

    task automatic one_stream(input int md, input logic [3:0] mask, input int len);
        int base;
        int w;
        string ptag;
        @(negedge clk);
        check("R7 idle gap grant", 32'(gnt_o), 0);
        check("R8 idle valid", 32'(out_valid_o), 0);
        mode_sel = 2'(md);
        req_i    = mask;
        last_i   = '0;
        put_bytes(0);
        base = (md == 1) ? rot_m : (md == 2) ? rr_m : 0;
        w    = model_pick(mask, base);
        ptag = (md == 1) ? "R4 rotating pick" : (md == 2) ? "R5 round-robin pick" : "R2 fixed pick";
        for (int b = 0; b < len; b++) begin
            @(negedge clk);
            if (b == 0) begin
                check(ptag, 32'(gnt_o), 32'(1 << w));
                check("R1 grant index", 32'(gnt_idx_o), 32'(w));
            end else begin
                check("R3/R9 lock hold", 32'(gnt_o), 32'(1 << w));
            end
            put_bytes(b);
            last_i = (b == len - 1) ? 4'(1 << w) : 4'b0;
            if (b == 0 && len > 1) begin
                req_i    = 4'hF;
                mode_sel = 2'((md + 1) % 3);
            end
            #1;
            check("R1 forwarded byte", 32'(out_data_o), 32'(pattern(w, b)));
            check("R1 forwarded valid", 32'(out_valid_o), 1);
            check("R7 last flag", 32'(out_last_o), (b == len - 1) ? 1 : 0);
        end
        if (md == 1) rot_m = (rot_m + 1) % 4;
        if (md == 2) rr_m  = (w + 1) % 4;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset grant", 32'(gnt_o), 0);
        check("R10 reset valid", 32'(out_valid_o), 0);
        rst_n = 1'b1;

        // R8: no request, no grant
        @(negedge clk);
        req_i = '0;
        @(negedge clk);
        check("R8 no request grant", 32'(gnt_o), 0);
        check("R8 no request last", 32'(out_last_o), 0);

        for (int md = 0; md < 3; md++) begin
            for (int m = 1; m < 16; m++) begin
                one_stream(md, 4'(m), 1 + (m % 3));
            end
        end

        // reserved code behaves as fixed
        one_stream(0, 4'b1100, 2);
        @(negedge clk);
        mode_sel = 2'd3;
        req_i    = 4'b0110;
        last_i   = '0;
        @(negedge clk);
        check("R2 reserved code fixed", 32'(gnt_o), 32'(4'b0010));
        last_i = 4'b0010;
        #1;
        check("R7 reserved last", 32'(out_last_o), 1);
        @(negedge clk);
        req_i = '0;
        check("R7 release", 32'(gnt_o), 0);
        @(negedge clk);
        check("R8 idle after release", 32'(gnt_o), 0);

        // R10: pointers back to source 0 after reset
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rot_m = 0;
        rr_m  = 0;
        one_stream(1, 4'hF, 1);
        one_stream(2, 4'b1001, 1);
        one_stream(2, 4'b1001, 1);
        @(negedge clk);
        rst_n = 1'b0;
        req_i = 4'hF;
        mode_sel = 2'd2;
        @(negedge clk);
        check("R10 reset clears lock", 32'(gnt_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 round-robin pointer at r0", 32'(gnt_o), 32'(4'b0001));
        last_i = 4'b0001;
        @(negedge clk);
        req_i  = '0;
        last_i = '0;
        @(negedge clk);

        summary();
        $finish;
    end
endmodule